// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block watches for a program that has stopped servicing it. A free-running prescaler divides the bus clock. Each prescaler tick steps a down-counter by one. When the counter would step below zero, the block emits a one-cycle interrupt request and reloads the counter with all ones. Software must write the start/refresh register often enough that this never happens.

A narrow write port reaches two registers. The control register holds a ratio-select bit in its top data bit. The start/refresh register reacts only to its write strobe. A clock-source input marks the bus clock as coming from the slow sub oscillator, and in that case the divide-by-2 ratio is forced. A hold input freezes both the prescaler and the counter. After reset the block does nothing until the first start write. Reading the control register shows the ratio bit together with the counter's most significant bits.

Top module: `wdog_core`

## Requirements
- R1: Reset leaves the counter at all ones, `irq_o` low, and `ctrl_rdata_o` with the ratio bit (bit DATA_W-1) at 0 and every lower bit at 1.
- R2: Until the first write to the start address (default 3), neither the prescaler nor the counter moves, and no interrupt request is raised.
- R3: The prescale ratio is 2 when `sub_osc_i` is 1. When `sub_osc_i` is 0, the ratio is 16 if the ratio bit is 0 and 128 if it is 1. The counter steps down by exactly one per tick. Starting from prescaler phase 0, `irq_o` rises ratio × 2^CNT_W bus cycles after the start write.
- R4: `irq_o` is high for exactly one cycle. It is registered, so it is seen in the cycle after the edge on which a tick meets a counter value of zero. On that same edge the counter reloads to all ones and keeps counting, so the next request follows one full period later.
- R5: Every write to the start address reloads the counter to all ones, whatever data is written. It leaves the ratio bit unchanged, and counting stays enabled until the next reset.
- R6: Start writes and interrupt events never clear the prescaler. After a restart with prescaler phase p, the first tick arrives ratio − (p mod ratio) cycles later, or a full ratio when that remainder is 0.
- R7: While `hold_i` is 1, neither the prescaler nor the counter advances. Each held cycle delays the next interrupt by one cycle.
- R8: `ctrl_rdata_o` returns the last written ratio bit in bit DATA_W-1. The bits below it carry the counter's most significant bits, so with CNT_W=8 and DATA_W=8 the low seven bits are counter bits 7:1. A write to the control address (default 2) stores the ratio bit on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sub_osc_i | input | 1 | 1 = bus clock taken from sub oscillator, forces divide by 2 |
| hold_i | input | 1 | Freezes prescaler and counter while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register select for the write |
| wr_data_i | input | DATA_W | Write data; only the top bit is stored, and only at the control address |
| ctrl_rdata_o | output | DATA_W | Control register view: ratio bit over counter MSBs |
| irq_o | output | 1 | One-cycle watchdog interrupt request |

## Verification
A prescaler whose phase was wrongly cleared, or a counter that missed or doubled a step, moves the interrupt pulse off its exact bus cycle. The scoreboard catches that the moment the expected cycle passes or an unexpected pulse appears, which is at most one prescaler ratio after the fault for a phase error. A counter that ran while idle or held, or a ratio bit that was lost, already shows in the control readback at the next sample, well before any timeout. Restarts are made at nonzero prescaler phases, so a design that reset the prescaler on a start write would fire early by a predictable number of cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      DIV_SUB = 2'd0,
      DIV_LO  = 2'd1,
      DIV_HI  = 2'd2
   } div_sel_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      m = (m > c) ? m : c;
      return (m < 1) ? 1 : m;
   endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 2,
   parameter int START_ADDR = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              wr_ratio_i,
   output logic              ratio_hi_o,
   output logic              start_o,
   output logic              started_o
);
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_ADDR);

   logic ratio_q;
   logic started_q;
   logic ctrl_wr;

   if (CTRL_ADDR == START_ADDR) begin : g_bad_addr
      $error("control and start addresses must differ");
   end

   assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_A);
   assign start_o = wr_en_i && (wr_addr_i == START_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q   <= 1'b0;
         started_q <= 1'b0;
      end else begin
         if (ctrl_wr) ratio_q <= wr_ratio_i;
         if (start_o) started_q <= 1'b1;
      end
   end

   assign ratio_hi_o = ratio_q;
   assign started_o  = started_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
   import wdog_pkg::*;
#(
   parameter int LOG2_SUB = 1,
   parameter int LOG2_LO  = 4,
   parameter int LOG2_HI  = 7,
   localparam int PRE_W   = max3(LOG2_SUB, LOG2_LO, LOG2_HI)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  div_sel_e         sel_i,
   output logic [PRE_W-1:0] pre_o,
   output logic             tick_o
);
   logic [PRE_W-1:0] pre_q;
   logic [2:0]       hit;
   logic             sel_hit;

   if (LOG2_SUB < 0 || LOG2_LO < 0 || LOG2_HI < 0 || PRE_W > 16) begin : g_bad_ratio
      $error("prescale exponents must lie in 0..16");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_q <= '0;
      else if (active_i) pre_q <= pre_q + 1'b1;
   end

   for (genvar i = 0; i < 3; i++) begin : g_opt
      localparam int L = (i == 0) ? LOG2_SUB : ((i == 1) ? LOG2_LO : LOG2_HI);
      if (L == 0) begin : g_div1
         assign hit[i] = 1'b1;
      end else begin : g_divn
         assign hit[i] = &pre_q[L-1:0];
      end
   end

   always_comb begin
      case (sel_i)
         DIV_SUB: sel_hit = hit[0];
         DIV_LO:  sel_hit = hit[1];
         DIV_HI:  sel_hit = hit[2];
         default: sel_hit = 1'b0;
      endcase
   end

   assign tick_o = active_i && sel_hit;
   assign pre_o  = pre_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             uflow_o
);
   localparam logic [CNT_W-1:0] RELOAD = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             uflow_q;
   logic             at_zero;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("counter width must lie in 2..32");
   end

   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= RELOAD;
         uflow_q <= 1'b0;
      end else begin
         uflow_q <= !load_i && tick_i && at_zero;
         if (load_i)                cnt_q <= RELOAD;
         else if (tick_i && at_zero) cnt_q <= RELOAD;
         else if (tick_i)           cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign uflow_o = uflow_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int CNT_W      = 15,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 2,
   parameter int START_ADDR = 3,
   parameter int LOG2_SUB   = 1,
   parameter int LOG2_LO    = 4,
   parameter int LOG2_HI    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sub_osc_i,
   input  logic              hold_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] ctrl_rdata_o,
   output logic              irq_o
);
   localparam int PRE_W = max3(LOG2_SUB, LOG2_LO, LOG2_HI);
   localparam int RB_W  = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_data
      $error("data width must be at least 2");
   end
   if (ADDR_W < 1 || CTRL_ADDR >= (1 << ADDR_W) || START_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("register addresses must fit the address width");
   end

   logic             ratio_hi;
   logic             start_pulse;
   logic             started;
   logic             active;
   div_sel_e         div_sel;
   logic [PRE_W-1:0] pre_q;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic [RB_W-1:0]  cnt_view;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^wr_data_i[DATA_W-2:0];

   wdog_regs #(
      .ADDR_W     (ADDR_W),
      .CTRL_ADDR  (CTRL_ADDR),
      .START_ADDR (START_ADDR)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_ratio_i (wr_data_i[DATA_W-1]),
      .ratio_hi_o (ratio_hi),
      .start_o    (start_pulse),
      .started_o  (started)
   );

   assign active  = started && !hold_i;
   assign div_sel = sub_osc_i ? DIV_SUB : (ratio_hi ? DIV_HI : DIV_LO);

   wdog_prescaler #(
      .LOG2_SUB (LOG2_SUB),
      .LOG2_LO  (LOG2_LO),
      .LOG2_HI  (LOG2_HI)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .sel_i    (div_sel),
      .pre_o    (pre_q),
      .tick_o   (tick)
   );

   wdog_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (start_pulse),
      .tick_i  (tick),
      .cnt_o   (cnt_q),
      .uflow_o (irq_o)
   );

   if (CNT_W >= RB_W) begin : g_view_top
      assign cnt_view = cnt_q[CNT_W-1 -: RB_W];
   end else begin : g_view_pad
      assign cnt_view = {{(RB_W-CNT_W){1'b0}}, cnt_q};
   end

   assign ctrl_rdata_o = {ratio_hi, cnt_view};
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
   parameter int CNT_W     = 15,
   parameter int PRE_W     = 7,
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_i,
   input logic              start_pulse,
   input logic              started,
   input logic              irq_o,
   input logic              wr_en_i,
   input logic              wr_ratio_bit,
   input logic              ratio_rb,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [PRE_W-1:0]  pre_q,
   input logic [CNT_W-1:0]  cnt_q
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !started |=> $stable(pre_q));

   assert_idle_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (cnt_q == '1) && !irq_o);

   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_pulse && cnt_q != '0) |=>
         (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1)));

   assert_irq_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(cnt_q) == '0);

   assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_irq_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> cnt_q == '1);

   assert_start_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> (cnt_q == '1) && !irq_o && started);

   assert_phase_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse && started && !hold_i) |=> pre_q == $past(pre_q) + PRE_W'(1));

   assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !start_pulse) |=> $stable(cnt_q) && $stable(pre_q));

   assert_ratio_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == CTRL_A) |=> ratio_rb == $past(wr_ratio_bit));
endmodule

bind wdog_core wdog_checker #(
   .CNT_W     (CNT_W),
   .PRE_W     (PRE_W),
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hold_i       (hold_i),
   .start_pulse  (start_pulse),
   .started      (started),
   .irq_o        (irq_o),
   .wr_en_i      (wr_en_i),
   .wr_ratio_bit (wr_data_i[DATA_W-1]),
   .ratio_rb     (ctrl_rdata_o[DATA_W-1]),
   .wr_addr_i    (wr_addr_i),
   .pre_q        (pre_q),
   .cnt_q        (cnt_q)
);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 8;
   localparam int DATA_W     = 8;
   localparam int ADDR_W     = 2;
   localparam logic [ADDR_W-1:0] CTRL_A  = 2'd2;
   localparam logic [ADDR_W-1:0] START_A = 2'd3;
   localparam int unsigned SPAN = (1 << CNT_W);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sub_osc = 1'b0;
   logic              hold = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rdata;
   logic              irq;

   wdog_core #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_wdog_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .sub_osc_i    (sub_osc),
      .hold_i       (hold),
      .wr_en_i      (wr_en),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .ctrl_rdata_o (rdata),
      .irq_o        (irq)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int unsigned cyc;
      string       req;
   } exp_t;

   exp_t        exp_q[$];
   int unsigned cyc = 0;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   // Requirement-level model of the prescaler phase (R2, R6, R7)
   bit          en_ref = 1'b0;
   int unsigned ref_phase = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         en_ref    <= 1'b0;
         ref_phase <= 0;
      end else begin
         if (en_ref && !hold) ref_phase <= (ref_phase + 1) % 128;
         if (wr_en && wr_addr == START_A) en_ref <= 1'b1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // Monitor: pops expected interrupt cycles and compares
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (irq) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2/R4", "unexpected irq at cycle", cyc, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.cyc == cyc, e.req, "irq cycle", cyc, e.cyc);
            end
         end else if (exp_q.size() > 0 && cyc > exp_q[0].cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            check(1'b0, e.req, "missed irq, now at cycle", cyc, e.cyc);
         end
      end
   end

   task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            output int unsigned edge_no);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
      edge_no = cyc;
   endtask

   // Driver: writes start and pushes the expected interrupt cycles
   task automatic start_run(input int unsigned ratio, input logic [DATA_W-1:0] d,
                            input int unsigned extra, input int periods,
                            input string req, output int unsigned w);
      int unsigned pm;
      int unsigned k1;
      reg_write(START_A, d, w);
      pm = ref_phase % ratio;
      k1 = (pm == 0) ? ratio : ratio - pm;
      for (int i = 0; i < periods; i++) begin
         exp_t e;
         e.cyc = w + k1 + (SPAN - 1) * ratio + extra + i * ratio * SPAN;
         e.req = req;
         exp_q.push_back(e);
      end
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      check(1'b0, "all", "watchdog expired at cycle", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : driver
      int unsigned w;
      int unsigned tmp;
      logic [DATA_W-1:0] snap;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(irq == 1'b0, "R1", "irq after reset", irq, 0);
      check(rdata == 8'h7F, "R1", "readback after reset", rdata, 8'h7F);

      // R2: idle until first start write
      repeat (1000) @(negedge clk);
      check(rdata == 8'h7F, "R2", "readback while idle", rdata, 8'h7F);

      // R8: ratio bit stored, other data bits not
      reg_write(CTRL_A, 8'hB5, tmp);
      check(rdata == 8'hFF, "R8", "readback after ctrl write 1", rdata, 8'hFF);
      reg_write(CTRL_A, 8'h4A, tmp);
      check(rdata == 8'h7F, "R8", "readback after ctrl write 0", rdata, 8'h7F);
      check(ref_phase == 0, "R2", "bench phase still zero", ref_phase, 0);

      // R3/R4: divide by 16 from phase 0, two periods
      start_run(16, 8'h00, 0, 2, "R3_R4_div16", w);
      repeat (160) @(negedge clk);
      check(rdata == 8'd122, "R8", "readback after 10 ticks", rdata, 122);
      drain();

      // R5/R6: refresh before timeout, restart at nonzero phase
      reg_write(START_A, 8'hFF, w);
      check(rdata[DATA_W-1] == 1'b0, "R5", "ratio bit after start write", rdata[DATA_W-1], 0);
      check(rdata == 8'h7F, "R5", "reload on start write", rdata, 8'h7F);
      repeat (3000) @(negedge clk);
      while (ref_phase % 16 == 0) @(negedge clk);
      check(rdata != 8'h7F, "R5", "counting continued after start", rdata, 0);
      start_run(16, 8'h5C, 0, 1, "R6_refresh", w);
      drain();

      // R3: divide by 128
      reg_write(CTRL_A, 8'h80, tmp);
      start_run(128, 8'h01, 0, 1, "R3_div128", w);
      drain();

      // R3/R4: sub oscillator forces divide by 2 despite ratio bit 1
      sub_osc = 1'b1;
      start_run(2, 8'h33, 0, 2, "R3_R4_sub", w);
      drain();

      // R7: hold freezes everything, delays irq by held cycles
      start_run(2, 8'hC3, 300, 1, "R7_hold", w);
      repeat (100) @(negedge clk);
      hold = 1'b1;
      snap = rdata;
      repeat (300) @(negedge clk);
      check(rdata == snap, "R7", "readback during hold", rdata, snap);
      hold = 1'b0;
      drain();

      check(exp_q.size() == 0, "R4", "pending expectations", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule